// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, in each cycle, which hardware thread the front end should fetch for. Every thread reports a 3-bit fetch status, and an active mask says which threads exist in the running workload. From these the block builds an eligible set. A static policy input then picks one eligible thread.

There are four policies. The first serves thread 0 only. The second is fair rotation over an internal priority list. The last two prefer the thread whose issue-queue occupancy is lowest, or whose load/store-queue occupancy is lowest. The result is offered as a valid/thread-ID pair with a ready input from the consumer. A grant counts as taken only in a cycle where valid and ready are both high. When ready is low, the offer may change if the inputs change, but no internal state moves. When no thread qualifies, valid is low.

With a single configured thread, the policy input is ignored and the single-thread rule applies.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only if its status code is 0 (running), 1 (idle) or 4 (line fill complete). Codes 2, 3, 5, 6 and 7 make it ineligible.
- R2: A thread whose active-mask bit is 0 is never offered.
- R3: Under the rotation policy (code 1), the offered thread is the first eligible thread found when scanning the priority list from its head.
- R4: When a rotation grant is taken, the granted thread is moved to the tail of the list in the next cycle, and the other threads keep their relative order.
- R5: When no thread is eligible under the selected policy, sel_valid is 0 and the priority list is left unchanged.
- R6: While sel_ready is 0, the priority list holds its value. The same offer is repeated while the inputs are unchanged.
- R7: Under the single-thread policy (code 0), only thread 0 is offered: valid exactly when thread 0 is active and eligible, with ID 0.
- R8: Under the issue-queue policy (code 2), the offer is the eligible thread with the smallest issue-queue count. Ties go to the lowest thread ID.
- R9: Under the load/store policy (code 3), the offer is the eligible thread with the smallest load/store-queue count, regardless of issue-queue counts. Ties go to the lowest thread ID.
- R10: After reset, the priority list holds the thread IDs in ascending order, with thread 0 at the head.
- R11: The priority list changes only when a grant is taken under the rotation policy. Grants taken under other policies leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_sel | input | 2 | 0 single, 1 rotation, 2 issue-queue count, 3 load/store count |
| active_mask | input | N_THREADS | Active-thread mask, one bit per thread |
| thread_status | input | 3*N_THREADS | Per-thread fetch status code; thread i occupies bits [3i+2:3i] |
| iq_count | input | CNT_W*N_THREADS | Per-thread issue-queue occupancy, packed by thread |
| lsq_count | input | CNT_W*N_THREADS | Per-thread load/store-queue occupancy, packed by thread |
| sel_valid | output | 1 | A thread is offered this cycle |
| sel_ready | input | 1 | Consumer takes the offered thread |
| sel_tid | output | max(1,clog2(N_THREADS)) | Offered thread ID |

## Verification
The assertions assume the following about the inputs:
- Policy, mask, status and counts are stable between clock edges.
- The consumer acts only on the offer seen in the same cycle.

Every 3-bit status value is legal, so the assertions can hold under any code. The stimulus changes inputs only at the falling edge and holds them for a full cycle, and it sweeps all eight status codes. Back-pressure is exercised by holding ready low for runs of cycles and by randomising it in a mixed phase.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int STW = 3;

  typedef enum logic [STW-1:0] {
    ST_RUN        = 3'd0,
    ST_IDLE       = 3'd1,
    ST_SQUASH     = 3'd2,
    ST_BLOCK      = 3'd3,
    ST_FILLED     = 3'd4,
    ST_WAIT_RESP  = 3'd5,
    ST_WAIT_RETRY = 3'd6,
    ST_PARKED     = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_ROTATE = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } fetch_pol_e;

  function automatic logic can_fetch(input logic [STW-1:0] code);
    return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_FILLED);
  endfunction
endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
  import fsel_pkg::*;
#(
  parameter int N_THREADS = 4
) (
  input  logic [N_THREADS-1:0]     active_mask,
  input  logic [STW*N_THREADS-1:0] thread_status,
  output logic [N_THREADS-1:0]     elig
);
  for (genvar i = 0; i < N_THREADS; i++) begin : g_thr
    assign elig[i] = active_mask[i] && can_fetch(thread_status[i*STW +: STW]);
  end
endmodule

// File: rtl/fsel_rr_list.sv
module fsel_rr_list #(
  parameter int N_THREADS = 4,
  parameter int TW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_THREADS-1:0] elig,
  input  logic                 advance,
  output logic                 hit,
  output logic [TW-1:0]        hit_tid
);
  logic [TW-1:0] order_q [N_THREADS];
  logic [TW-1:0] order_n [N_THREADS];
  logic [TW*N_THREADS-1:0] order_flat;
  logic [N_THREADS-1:0] seen;
  int hit_pos;

  always_comb begin
    hit = 1'b0;
    hit_pos = 0;
    hit_tid = '0;
    for (int p = 0; p < N_THREADS; p++) begin
      if (!hit && elig[order_q[p]]) begin
        hit = 1'b1;
        hit_pos = p;
        hit_tid = order_q[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < N_THREADS; p++) begin
      if (p < hit_pos)
        order_n[p] = order_q[p];
      else if (p < N_THREADS - 1)
        order_n[p] = order_q[(p < N_THREADS - 1) ? p + 1 : p];
      else
        order_n[p] = hit_tid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N_THREADS; p++) order_q[p] <= TW'(p);
    end else if (advance && hit) begin
      for (int p = 0; p < N_THREADS; p++) order_q[p] <= order_n[p];
    end
  end

  for (genvar p = 0; p < N_THREADS; p++) begin : g_flat
    assign order_flat[p*TW +: TW] = order_q[p];
  end

  always_comb begin
    seen = '0;
    for (int p = 0; p < N_THREADS; p++) seen[order_q[p]] = 1'b1;
  end

  // R5, R6: no taken rotation grant leaves the list untouched
  a_r6_list_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(order_flat));
  // R4: taken thread lands at the tail
  a_r4_tail: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> order_q[N_THREADS-1] == $past(hit_tid));
  // R4: list always stays a permutation of all thread IDs
  a_r4_perm: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);
  // R5: a rotation grant is never taken without a hit
  a_r5_no_empty_take: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> hit);
endmodule

// File: rtl/fsel_min_pick.sv
module fsel_min_pick #(
  parameter int N_THREADS = 4,
  parameter int CNT_W = 6,
  parameter int TW = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_THREADS-1:0]       elig,
  input  logic [CNT_W*N_THREADS-1:0] counts,
  output logic                       found,
  output logic [TW-1:0]              pick_tid
);
  logic [CNT_W-1:0] best;

  always_comb begin
    found = 1'b0;
    pick_tid = '0;
    best = '0;
    for (int i = 0; i < N_THREADS; i++) begin
      if (elig[i] && (!found || counts[i*CNT_W +: CNT_W] < best)) begin
        found = 1'b1;
        pick_tid = TW'(i);
        best = counts[i*CNT_W +: CNT_W];
      end
    end
  end

  // R8, R9: a pick is always an eligible thread
  a_r8_pick_elig: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> elig[pick_tid]);
  // R5: nothing eligible means nothing found
  a_r5_none: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !found);
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fsel_pkg::*;
#(
  parameter int N_THREADS = 4,
  parameter int CNT_W = 6,
  localparam int TW = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 policy_sel,
  input  logic [N_THREADS-1:0]       active_mask,
  input  logic [STW*N_THREADS-1:0]   thread_status,
  input  logic [CNT_W*N_THREADS-1:0] iq_count,
  input  logic [CNT_W*N_THREADS-1:0] lsq_count,
  output logic                       sel_valid,
  input  logic                       sel_ready,
  output logic [TW-1:0]              sel_tid
);
  logic [N_THREADS-1:0] elig;
  fetch_pol_e eff_pol;
  logic rr_hit, mp_found, advance;
  logic [TW-1:0] rr_tid, mp_tid;
  logic [CNT_W*N_THREADS-1:0] rank_counts;

  if (N_THREADS == 1) begin : g_one
    assign eff_pol = POL_SINGLE;
  end else begin : g_many
    assign eff_pol = fetch_pol_e'(policy_sel);
  end

  fsel_elig #(.N_THREADS(N_THREADS)) u_elig (
    .active_mask(active_mask), .thread_status(thread_status), .elig(elig));

  assign advance = sel_valid && sel_ready && (eff_pol == POL_ROTATE);

  fsel_rr_list #(.N_THREADS(N_THREADS), .TW(TW)) u_rr (
    .clk(clk), .rst_n(rst_n), .elig(elig), .advance(advance),
    .hit(rr_hit), .hit_tid(rr_tid));

  assign rank_counts = (eff_pol == POL_LSQ) ? lsq_count : iq_count;

  fsel_min_pick #(.N_THREADS(N_THREADS), .CNT_W(CNT_W), .TW(TW)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .counts(rank_counts),
    .found(mp_found), .pick_tid(mp_tid));

  always_comb begin
    unique case (eff_pol)
      POL_SINGLE: begin sel_valid = elig[0]; sel_tid = '0;     end
      POL_ROTATE: begin sel_valid = rr_hit;  sel_tid = rr_tid; end
      default:    begin sel_valid = mp_found; sel_tid = mp_tid; end
    endcase
  end

  // R2: only active threads are offered
  a_r2_active: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> active_mask[sel_tid]);
  // R1: offered thread carries a fetchable status code
  a_r1_status: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (thread_status[sel_tid*STW +: STW] inside {3'd0, 3'd1, 3'd4}));
  // R7: single-thread policy offers thread 0 only
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && policy_sel == 2'd0) |-> sel_tid == '0);
endmodule

// File: tb/sim_fetch_thread_sel.sv
`timescale 1ns/1ps
module sim_fetch_thread_sel;
  localparam int N = 4;
  localparam int CW = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] policy_sel = 2'd1;
  logic [N-1:0] active_mask = '1;
  logic [3*N-1:0] thread_status = '0;
  logic [CW*N-1:0] iq_count = '0;
  logic [CW*N-1:0] lsq_count = '0;
  logic sel_ready = 0;
  logic sel_valid;
  logic [1:0] sel_tid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ml [N];

  typedef struct { bit v; int t; string req; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  fetch_thread_sel #(.N_THREADS(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .active_mask(active_mask),
    .thread_status(thread_status), .iq_count(iq_count), .lsq_count(lsq_count),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_tid(sel_tid));

  function automatic bit ok_code(input int c);
    return c == 0 || c == 1 || c == 4;
  endfunction

  function automatic logic [3*N-1:0] st4(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  function automatic logic [CW*N-1:0] c4(input int a, input int b, input int c, input int d);
    return {6'(d), 6'(c), 6'(b), 6'(a)};
  endfunction

  task automatic drive(input int pol, input logic [N-1:0] act, input logic [3*N-1:0] st,
                       input logic [CW*N-1:0] iq, input logic [CW*N-1:0] lsq,
                       input bit rdy, input string req);
    bit el [N];
    exp_t e;
    int pos;
    @(negedge clk);
    policy_sel = 2'(pol); active_mask = act; thread_status = st;
    iq_count = iq; lsq_count = lsq; sel_ready = rdy;
    for (int i = 0; i < N; i++) el[i] = act[i] && ok_code(int'(st[i*3 +: 3]));
    e.v = 0; e.t = 0; e.req = req; pos = -1;
    if (pol == 0) begin
      e.v = el[0]; e.t = 0;
    end else if (pol == 1) begin
      for (int p = 0; p < N; p++)
        if (!e.v && el[ml[p]]) begin e.v = 1; e.t = ml[p]; pos = p; end
    end else begin
      int best;
      best = 0;
      for (int i = 0; i < N; i++) begin
        int c;
        c = (pol == 2) ? int'(iq[i*CW +: CW]) : int'(lsq[i*CW +: CW]);
        if (el[i] && (!e.v || c < best)) begin e.v = 1; e.t = i; best = c; end
      end
    end
    #1 q.push_back(e);
    if (pol == 1 && rdy && e.v) begin
      for (int p = pos; p < N - 1; p++) ml[p] = ml[p+1];
      ml[N-1] = e.t;
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (sel_valid !== e.v || (e.v && int'(sel_tid) != e.t)) begin
          errors++;
          $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                   e.req, sel_valid, sel_tid, e.v, e.t);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [3*N-1:0] all_run;
    all_run = st4(0, 0, 0, 0);
    for (int i = 0; i < N; i++) ml[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: head after reset is thread 0
    drive(1, 4'hF, all_run, '0, '0, 0, "R10");
    // R3, R4: rotation through all threads and wrap
    for (int k = 0; k < 5; k++) drive(1, 4'hF, all_run, '0, '0, 1, "R4");
    // R6: back-pressure holds the list
    for (int k = 0; k < 3; k++) drive(1, 4'hF, all_run, '0, '0, 0, "R6");
    // R3: skip ineligible head entries
    drive(1, 4'hF, st4(3, 2, 0, 0), '0, '0, 1, "R3");
    drive(1, 4'hF, st4(5, 0, 6, 0), '0, '0, 1, "R3");
    // R5: nothing eligible, list unchanged
    for (int k = 0; k < 2; k++) drive(1, 4'hF, st4(2, 3, 5, 7), '0, '0, 1, "R5");
    drive(1, 4'hF, all_run, '0, '0, 0, "R5");
    // R1: sweep status codes on thread 1 alone
    for (int c = 0; c < 8; c++) drive(1, 4'b0010, st4(0, c, 0, 0), '0, '0, 1, "R1");
    // R2: inactive threads never offered
    drive(1, 4'b0000, all_run, '0, '0, 1, "R2");
    for (int k = 0; k < 3; k++) drive(1, 4'b1010, all_run, '0, '0, 1, "R2");
    // R7, R11: single policy
    drive(0, 4'hF, all_run, '0, '0, 1, "R7");
    drive(0, 4'hF, st4(3, 0, 0, 0), '0, '0, 1, "R7");
    drive(0, 4'b1110, all_run, '0, '0, 1, "R7");
    drive(1, 4'hF, all_run, '0, '0, 0, "R11");
    // R8: issue-queue ranking, tie to lowest ID
    drive(2, 4'hF, all_run, c4(9, 3, 7, 5), c4(0, 9, 9, 9), 1, "R8");
    drive(2, 4'hF, all_run, c4(9, 4, 7, 4), '0, 1, "R8");
    drive(2, 4'hF, st4(0, 3, 0, 0), c4(9, 1, 7, 8), '0, 1, "R8");
    drive(2, 4'hF, all_run, c4(5, 5, 5, 5), '0, 1, "R8");
    // R9: load/store ranking ignores issue counts
    drive(3, 4'hF, all_run, c4(0, 9, 9, 9), c4(8, 6, 2, 2), 1, "R9");
    drive(3, 4'b1011, all_run, c4(0, 0, 0, 0), c4(8, 6, 1, 7), 1, "R9");
    drive(3, 4'hF, st4(0, 0, 0, 0), '0, c4(63, 62, 63, 63), 1, "R9");
    // R11: list unchanged by count-policy grants
    drive(1, 4'hF, all_run, '0, '0, 0, "R11");
    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      logic [3*N-1:0] st;
      st = '0;
      for (int i = 0; i < N; i++) st[i*3 +: 3] = ($urandom % 2) ? 3'd0 : 3'($urandom % 8);
      drive(int'($urandom % 4), 4'($urandom), st, (CW*N)'({$urandom, $urandom}),
            (CW*N)'({$urandom, $urandom}), bit'($urandom % 2), "R3/R8 mixed");
    end
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R3: got %0d unchecked items, expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule